// File: doc/BRIEF.md
# Thirteen-Level Phase-Disposition PWM Level Generator

This block produces the staircase command for a cascaded multilevel inverter. An internal phase accumulator walks a quarter-wave sine table to form a reference. The reference is split into a magnitude and a sign, and the magnitude is scaled by a modulation-index input. The magnitude is then compared against six triangular carriers. The carriers are in phase, have the same amplitude, and are stacked one above the other so that their bands touch. The number of carriers the magnitude lies strictly above is the level magnitude. The sign of the reference selects the half-cycle, so together they give a signed level from -6 to +6.

All carriers come from one shared up/down counter plus a per-band offset, so they cannot drift apart. The carrier rate is set by a period input: the counter takes one step every period+1 clocks. A new period takes effect only when the counter reaches its trough, so every carrier cycle runs at a single rate. The reference frequency is set by a phase-step word. Gate mapping, dead time and the choice of source voltages are handled elsewhere.

Top module: `mcpd_level_gen`

## Requirements
- R1: While reset is asserted, `level` is 0 and `polarity` is 0.
- R2: One clock after any cycle, |`level`| equals the number of bands k in 0..5 for which r > k*256 + c (strict compare). In this rule, c is the carrier counter and r = floor(s*min(m,512)/512), where m is `mod_idx`. The table value s = round(1536*sin((a+0.5)*pi/128)). The table address a is phase bits [21:16], replaced by 63-a when phase bit 22 is 1.
- R3: `polarity` is the phase-accumulator bit 23 registered one clock later. When it is 1, `level` equals minus the count of R2; otherwise `level` equals the count.
- R4: The carrier counter runs as a triangle 0,1,...,256,255,...,0 and repeats, taking one step every P+1 clocks. After reset it starts at 0 rising, with P = 0.
- R5: The period input is copied into P only on the step that brings the carrier counter to 0. Changes at any other time have no effect until then.
- R6: A modulation index of 0 forces `level` to 0 on the next clock.
- R7: Any modulation index of 512 or above behaves exactly like 512 (unity). At unity, |`level`| reaches 6 within a reference cycle.
- R8: The phase accumulator starts at 0 after reset and adds `ref_step` every clock, modulo 2^24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_idx | input | 10 | Modulation index, 512 = unity, larger values clamp |
| car_per | input | 8 | Carrier step interval minus one, adopted at trough |
| ref_step | input | 24 | Phase increment per clock for the reference |
| level | output | 4 | Signed level code, -6..+6 |
| polarity | output | 1 | 1 while the reference is in its negative half |

## Verification
A behavioural model is compared with the block on every clock across several patterns:
- Unity index with the fastest carrier exercises every band crossing and the full ±6 swing, so a wrong band offset or compare sense shows up.
- An over-range index must match unity exactly, which separates clamping from wrap-around.
- An index of zero must hold the output at 0.
- A slow carrier whose period is changed in mid-ramp shows whether the new period is taken only at the trough.
- A large phase step wraps the accumulator many times, which exposes errors in the quadrant mirroring and the sign split.

// File: rtl/mcpd_pkg.sv
package mcpd_pkg;

   typedef enum logic { DIR_UP = 1'b0, DIR_DN = 1'b1 } car_dir_e;

   // signed width able to hold -ncar..+ncar
   function automatic int lvl_width(input int ncar);
      return $clog2(ncar + 1) + 1;
   endfunction

   // full-scale reference amplitude: ncar bands of 2**band_w
   function automatic int full_scale(input int ncar, input int band_w);
      return ncar * (1 << band_w);
   endfunction

endpackage

// File: rtl/mcpd_phase_sine.sv
module mcpd_phase_sine #(
   parameter int PH_W   = 24,
   parameter int LUT_AW = 6,
   parameter int MI_W   = 10,
   parameter int FS     = 1536,
   parameter int MAG_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PH_W-1:0]   step,
   input  logic [MI_W-1:0]   idx,
   output logic [MAG_W-1:0]  ref_mag,
   output logic              ref_neg,
   output logic [PH_W-1:0]   phase
);
   localparam int    NPTS   = 1 << LUT_AW;
   localparam int    MI_FR  = MI_W - 1;
   localparam int    PROD_W = MAG_W + MI_W;
   localparam real   PI_C   = 3.141592653589793;
   localparam logic [MI_W-1:0] UNITY = MI_W'(1) << MI_FR;

   function automatic int quarter_pt(input int i);
      real ang;
      ang = ($itor(i) + 0.5) * PI_C / (2.0 * NPTS);
      return $rtoi($itor(FS) * $sin(ang) + 0.5);
   endfunction

   logic [MAG_W-1:0]  rom [NPTS];
   logic [PH_W-1:0]   ph_q;
   logic [1:0]        quad;
   logic [LUT_AW-1:0] raw_a;
   logic [LUT_AW-1:0] rd_a;
   logic [MI_W-1:0]   idx_c;
   logic [PROD_W-1:0] prod;

   for (genvar i = 0; i < NPTS; i++) begin : g_rom
      localparam logic [MAG_W-1:0] PT = MAG_W'(quarter_pt(i));
      assign rom[i] = PT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph_q <= '0;
      else        ph_q <= ph_q + step;
   end

   assign quad   = ph_q[PH_W-1 -: 2];
   assign raw_a  = ph_q[PH_W-3 -: LUT_AW];
   assign rd_a   = quad[0] ? ~raw_a : raw_a;
   assign idx_c  = (idx > UNITY) ? UNITY : idx;

   always_comb begin
      prod    = PROD_W'(rom[rd_a]) * PROD_W'(idx_c);
      ref_mag = MAG_W'(prod >> MI_FR);
   end

   assign ref_neg = quad[1];
   assign phase   = ph_q;
endmodule

// File: rtl/mcpd_carrier.sv
module mcpd_carrier
   import mcpd_pkg::*;
#(
   parameter int BAND_W = 8,
   parameter int PER_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [PER_W-1:0]  per_in,
   output logic [BAND_W:0]   car,
   output logic [PER_W-1:0]  per_act
);
   localparam int          CW  = BAND_W + 1;
   localparam logic [CW-1:0] TOP = CW'(1) << BAND_W;

   logic [PER_W-1:0] div_q;
   logic [CW-1:0]    c_q;
   car_dir_e         dir_q;
   logic             tick;

   assign tick = (div_q == per_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q   <= '0;
         c_q     <= '0;
         dir_q   <= DIR_UP;
         per_act <= '0;
      end else if (tick) begin
         div_q <= '0;
         if (dir_q == DIR_UP) begin
            c_q <= c_q + 1'b1;
            if (c_q + 1'b1 == TOP) dir_q <= DIR_DN;
         end else begin
            c_q <= c_q - 1'b1;
            if (c_q == CW'(1)) begin
               dir_q   <= DIR_UP;
               per_act <= per_in;
            end
         end
      end else begin
         div_q <= div_q + 1'b1;
      end
   end

   assign car = c_q;
endmodule

// File: rtl/mcpd_band_cmp.sv
module mcpd_band_cmp #(
   parameter int NCAR   = 6,
   parameter int BAND_W = 8,
   parameter int MAG_W  = 11,
   parameter int CNT_W  = 3
) (
   input  logic [MAG_W-1:0]  ref_mag,
   input  logic [BAND_W:0]   car,
   output logic [CNT_W-1:0]  cnt
);
   localparam int SW = MAG_W + 2;

   logic [NCAR-1:0] hit;

   for (genvar k = 0; k < NCAR; k++) begin : g_band
      localparam logic [SW-1:0] BASE = SW'(k) << BAND_W;
      assign hit[k] = SW'(ref_mag) > (BASE + SW'(car));
   end

   always_comb begin
      cnt = '0;
      for (int k = 0; k < NCAR; k++) cnt = cnt + CNT_W'(hit[k]);
   end
endmodule

// File: rtl/mcpd_level_gen.sv
module mcpd_level_gen
   import mcpd_pkg::*;
#(
   parameter int NCAR   = 6,
   parameter int BAND_W = 8,
   parameter int PH_W   = 24,
   parameter int LUT_AW = 6,
   parameter int MI_W   = 10,
   parameter int PER_W  = 8,
   localparam int LVL_W = lvl_width(NCAR)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [MI_W-1:0]         mod_idx,
   input  logic [PER_W-1:0]        car_per,
   input  logic [PH_W-1:0]         ref_step,
   output logic signed [LVL_W-1:0] level,
   output logic                    polarity
);
   localparam int FS    = full_scale(NCAR, BAND_W);
   localparam int MAG_W = $clog2(FS + 1);
   localparam int CNT_W = $clog2(NCAR + 1);

   if (NCAR < 1)              begin : g_bad_ncar  $error("NCAR must be at least 1"); end
   if (BAND_W < 2)            begin : g_bad_band  $error("BAND_W must be at least 2"); end
   if (LUT_AW < 2)            begin : g_bad_lut   $error("LUT_AW must be at least 2"); end
   if (MI_W < 2)              begin : g_bad_mi    $error("MI_W must be at least 2"); end
   if (PH_W < LUT_AW + 2)     begin : g_bad_ph    $error("PH_W too narrow for table"); end

   logic [MAG_W-1:0] ref_mag;
   logic             ref_neg;
   logic [PH_W-1:0]  phase;
   logic [BAND_W:0]  car_val;
   logic [PER_W-1:0] per_act;
   logic [CNT_W-1:0] cnt;
   logic signed [LVL_W-1:0] lvl_d;

   mcpd_phase_sine #(
      .PH_W(PH_W), .LUT_AW(LUT_AW), .MI_W(MI_W), .FS(FS), .MAG_W(MAG_W)
   ) u_ref (
      .clk(clk), .rst_n(rst_n), .step(ref_step), .idx(mod_idx),
      .ref_mag(ref_mag), .ref_neg(ref_neg), .phase(phase)
   );

   mcpd_carrier #(.BAND_W(BAND_W), .PER_W(PER_W)) u_car (
      .clk(clk), .rst_n(rst_n), .per_in(car_per), .car(car_val), .per_act(per_act)
   );

   mcpd_band_cmp #(
      .NCAR(NCAR), .BAND_W(BAND_W), .MAG_W(MAG_W), .CNT_W(CNT_W)
   ) u_cmp (
      .ref_mag(ref_mag), .car(car_val), .cnt(cnt)
   );

   always_comb begin
      lvl_d = signed'(LVL_W'(cnt));
      if (ref_neg) lvl_d = -lvl_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level    <= '0;
         polarity <= 1'b0;
      end else begin
         level    <= lvl_d;
         polarity <= ref_neg;
      end
   end
endmodule

// File: rtl/mcpd_level_chk.sv
module mcpd_level_chk #(
   parameter int NCAR   = 6,
   parameter int BAND_W = 8,
   parameter int MI_W   = 10,
   parameter int PER_W  = 8,
   parameter int LVL_W  = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [MI_W-1:0]         mod_idx,
   input logic signed [LVL_W-1:0] level,
   input logic                    polarity,
   input logic [BAND_W:0]         car_val,
   input logic [PER_W-1:0]        per_act
);
   localparam logic [BAND_W:0] TOP = (BAND_W+1)'(1) << BAND_W;

   AST_RST_CLEAR: assert property (@(posedge clk) !rst_n |=> (level == '0 && !polarity)); // R1
   AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (level <= LVL_W'(NCAR)) && (level >= -LVL_W'(NCAR))); // R2
   AST_NEG_SIGN:  assert property (@(posedge clk) disable iff (!rst_n) polarity |-> level <= 0); // R3
   AST_POS_SIGN:  assert property (@(posedge clk) disable iff (!rst_n) !polarity |-> level >= 0); // R3
   AST_CAR_TOP:   assert property (@(posedge clk) disable iff (!rst_n) car_val <= TOP); // R4
   AST_CAR_STEP:  assert property (@(posedge clk) disable iff (!rst_n)
      (car_val != $past(car_val)) |-> ((car_val == $past(car_val) + 1'b1) || (car_val + 1'b1 == $past(car_val)))); // R4
   AST_PER_TROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      (per_act != $past(per_act)) |-> (car_val == '0)); // R5
   AST_ZERO_IDX:  assert property (@(posedge clk) disable iff (!rst_n)
      (mod_idx == '0) |=> (level == '0)); // R6
endmodule

bind mcpd_level_gen mcpd_level_chk #(
   .NCAR(NCAR), .BAND_W(BAND_W), .MI_W(MI_W), .PER_W(PER_W), .LVL_W(LVL_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mod_idx(mod_idx), .level(level),
   .polarity(polarity), .car_val(car_val), .per_act(per_act)
);

// File: tb/sim_mcpd_level_gen.sv
module sim_mcpd_level_gen;
   localparam real PI_C = 3.141592653589793;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [9:0]        mod_idx = '0;
   logic [7:0]        car_per = '0;
   logic [23:0]       ref_step = '0;
   logic signed [3:0] level;
   logic              polarity;

   int n_vec = 0;
   int n_bad = 0;
   int max_mag = 0;
   bit done = 0;
   string cur_req = "R2";

   // reference model state
   int m_ph, m_c, m_up, m_div, m_per;
   int exp_lvl = 0;
   int exp_pol = 0;

   always #5 clk = ~clk;

   mcpd_level_gen u0 (
      .clk(clk), .rst_n(rst_n), .mod_idx(mod_idx), .car_per(car_per),
      .ref_step(ref_step), .level(level), .polarity(polarity)
   );

   function automatic int tbl(input int a);
      return $rtoi(1536.0 * $sin(($itor(a) + 0.5) * PI_C / (2.0 * 64)) + 0.5);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph = 0; m_c = 0; m_up = 1; m_div = 0; m_per = 0;
         exp_lvl = 0; exp_pol = 0;
      end else begin
         int q, a, s, m, r, cnt;
         q = (m_ph >> 22) & 3;
         a = (m_ph >> 16) & 63;
         if (q & 1) a = 63 - a;
         s = tbl(a);
         m = (mod_idx > 512) ? 512 : int'(mod_idx);
         r = (s * m) / 512;
         cnt = 0;
         for (int k = 0; k < 6; k++) if (r > k * 256 + m_c) cnt++;
         exp_pol = (q >= 2) ? 1 : 0;
         exp_lvl = exp_pol ? -cnt : cnt;
         m_ph = (m_ph + int'(ref_step)) & 32'h00FF_FFFF;
         if (m_div == m_per) begin
            m_div = 0;
            if (m_up) begin
               m_c++;
               if (m_c == 256) m_up = 0;
            end else begin
               m_c--;
               if (m_c == 0) begin m_up = 1; m_per = int'(car_per); end
            end
         end else m_div++;
      end
   end

   always @(negedge clk) begin
      if (!done) begin
         n_vec++;
         if (int'(level) != exp_lvl) begin
            n_bad++;
            $display("FAIL %s level actual %0d expected %0d at %0t", cur_req, level, exp_lvl, $time);
         end
         if (int'(polarity) != exp_pol) begin
            n_bad++;
            $display("FAIL R3 polarity actual %0d expected %0d at %0t", polarity, exp_pol, $time);
         end
         if (rst_n) begin
            int mg;
            mg = (level < 0) ? -int'(level) : int'(level);
            if (mg > max_mag) max_mag = mg;
         end
      end
   end

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp_v);
      n_vec++;
      if (act != exp_v) begin
         n_bad++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp_v);
      end
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin @(posedge clk); cyc++; end
      if (!done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog actual %0d expected <150000 cycles", cyc);
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      cur_req = "R1";
      mod_idx = 10'd512; ref_step = 24'd8389;
      run(4);
      check("R1 level in reset", int'(level), 0);
      check("R1 polarity in reset", int'(polarity), 0);
      rst_n = 1'b1;
      // R2/R4/R8: unity index, fastest carrier, two reference cycles
      cur_req = "R2";
      run(4200);
      // R7: unity index reaches the top level
      check("R7 peak magnitude at unity", max_mag, 6);
      // R7: over-range index clamps to unity
      cur_req = "R7";
      mod_idx = 10'd1023;
      run(2500);
      // R6: zero index holds level at zero
      cur_req = "R6";
      mod_idx = 10'd0;
      run(600);
      check("R6 level at zero index", int'(level), 0);
      // R5: slower carrier, period changed while ramping
      cur_req = "R5";
      mod_idx = 10'd300; car_per = 8'd3;
      run(700);
      car_per = 8'd1;
      run(900);
      car_per = 8'd6;
      run(3000);
      // R4: half index, different period
      cur_req = "R4";
      max_mag = 0;
      mod_idx = 10'd256; car_per = 8'd0;
      run(3000);
      check("R4 magnitude bound at half index", (max_mag <= 3) ? 1 : 0, 1);
      // R8: large step, many accumulator wraps
      cur_req = "R8";
      mod_idx = 10'd480; ref_step = 24'd262144 + 24'd977;
      run(3000);
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule